// File: doc/BRIEF.md
# Quarter-Rate Wavefront Vector Core

This block is the vector execution part of a compute unit. It holds four independent SIMD engines. Each engine owns one resident wavefront of 64 work-items and a private vector register file that stores one 32-bit word per work-item per register. An engine has 16 integer ALU lanes, so a vector instruction is processed one quarter of the wavefront at a time: work-items 0–15 first, then 16–31, then 32–47, then 48–63. The instruction finishes after four cycles. An engine never overlaps two of its own instructions, so its throughput does not depend on data dependencies. Parallelism comes from the four engines running four separate wavefronts at once.

Each engine has its own issue port with a valid/ready handshake. The port carries an opcode, a destination register and two source registers. The engine raises a one-cycle completion pulse in the cycle that writes the last quarter. A shared test port reads and writes single register words, so software-free benches can seed and inspect the register files.

Top module: `wave_simd_core`

## Requirements
- R1: Opcode 0 writes dst = srcA + srcB and opcode 1 writes dst = srcA − srcB (modulo 2^32). Both apply independently to every one of the 64 work-items.
- R2: Opcode 2 writes the bitwise AND, opcode 3 the bitwise OR and opcode 4 the bitwise XOR of the two source words, for every work-item.
- R3: Opcode 5 writes the low 32 bits of the unsigned product srcA × srcB, for every work-item.
- R4: Opcodes 6 and 7 write no register. They still complete with the usual timing and completion pulse.
- R5: An instruction is accepted on a rising edge where valid and ready are both high. Ready is low for the three cycles after the accepting cycle and high again in the fourth. Back-to-back instructions are therefore accepted every four cycles, including when the second one reads the first one's result.
- R6: The completion pulse is high for exactly one cycle: the third cycle after the accepting cycle, which is the cycle whose closing edge writes work-items 48–63.
- R7: When the destination equals a source, every quarter computes from the register value as it was before the instruction started.
- R8: The four engines accept instructions in the same cycle, complete in the same cycle and change only their own register files.
- R9: The test port addresses an engine (0–3), a register (0–7) and a work-item (0–63). It reads the word combinationally. A write takes effect on the clock edge, but only when the addressed engine has ready high and valid low; otherwise the write is ignored.
- R10: Synchronous active-high reset sets every ready high and every completion pulse low and abandons any instruction in flight. It does not change register contents in quarters that the abandoned instruction had not yet reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 4 | Per-engine instruction valid |
| iss_ready | output | 4 | Per-engine ready to accept |
| iss_op | input | 12 | Per-engine opcode, 3 bits each, engine e at [3e+2:3e] |
| iss_dst | input | 12 | Per-engine destination register, 3 bits each |
| iss_srca | input | 12 | Per-engine first source register, 3 bits each |
| iss_srcb | input | 12 | Per-engine second source register, 3 bits each |
| done | output | 4 | Per-engine completion pulse |
| tst_simd | input | 2 | Test port engine select |
| tst_reg | input | 3 | Test port register select |
| tst_lane | input | 6 | Test port work-item select |
| tst_we | input | 1 | Test port write enable |
| tst_wdata | input | 32 | Test port write word |
| tst_rdata | output | 32 | Test port read word |

## Verification
The hardest situation to reach from the ports is an instruction whose quarters each read a register that earlier quarters of the same instruction are overwriting, together with a second instruction that depends on it and is issued back-to-back. The stimulus seeds every register with distinct per-work-item values. It then issues an instruction whose destination equals both sources. Next it holds valid high across a whole instruction so that the dependent instruction is taken in the very cycle ready returns. Last, it asserts reset in the middle of an instruction and test writes land while the engine is busy, which exposes partial-quarter state.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
   localparam int OPW = 3;

   localparam logic [OPW-1:0] OP_ADD   = 3'd0;
   localparam logic [OPW-1:0] OP_SUB   = 3'd1;
   localparam logic [OPW-1:0] OP_AND   = 3'd2;
   localparam logic [OPW-1:0] OP_OR    = 3'd3;
   localparam logic [OPW-1:0] OP_XOR   = 3'd4;
   localparam logic [OPW-1:0] OP_MULLO = 3'd5;

   // An opcode writes back only if it is one of the defined encodings.
   function automatic logic op_writes(input logic [OPW-1:0] op, input bit has_mul);
      logic ok;
      ok = (op <= OP_XOR) || (has_mul && (op == OP_MULLO));
      return ok;
   endfunction
endpackage

// File: rtl/wsc_lane_alu.sv
module wsc_lane_alu
   import wsc_pkg::*;
#(
   parameter int DW      = 32,
   parameter bit HAS_MUL = 1'b1
)(
   input  logic [OPW-1:0] op,
   input  logic [DW-1:0]  a,
   input  logic [DW-1:0]  b,
   output logic [DW-1:0]  y
);
   logic [DW-1:0] prod_lo;

   generate
      if (HAS_MUL) begin : g_mul
         assign prod_lo = a * b;
      end else begin : g_nomul
         assign prod_lo = '0;
      end
   endgenerate

   always_comb begin
      case (op)
         OP_ADD:   y = a + b;
         OP_SUB:   y = a - b;
         OP_AND:   y = a & b;
         OP_OR:    y = a | b;
         OP_XOR:   y = a ^ b;
         OP_MULLO: y = prod_lo;
         default:  y = '0;
      endcase
   end
endmodule

// File: rtl/wsc_vrf.sv
module wsc_vrf #(
   parameter int DW    = 32,
   parameter int NREG  = 8,
   parameter int WAVE  = 64,
   parameter int LANES = 16,
   localparam int RIDX = $clog2(NREG),
   localparam int LIDX = $clog2(WAVE),
   localparam int QN   = WAVE / LANES,
   localparam int QIDX = $clog2(QN),
   localparam int LQ   = $clog2(LANES)
)(
   input  logic               clk,
   input  logic [QIDX-1:0]    rd_q,
   input  logic [RIDX-1:0]    rd_a_idx,
   input  logic [RIDX-1:0]    rd_b_idx,
   output logic [LANES*DW-1:0] rd_a,
   output logic [LANES*DW-1:0] rd_b,
   input  logic               wr_en,
   input  logic [QIDX-1:0]    wr_q,
   input  logic [RIDX-1:0]    wr_idx,
   input  logic [LANES*DW-1:0] wr_data,
   input  logic               t_we,
   input  logic [RIDX-1:0]    t_idx,
   input  logic [LIDX-1:0]    t_lane,
   input  logic [DW-1:0]      t_wdata,
   output logic [DW-1:0]      t_rdata
);
   logic [DW-1:0] mem [NREG*WAVE];

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_rd
         assign rd_a[l*DW +: DW] = mem[{rd_a_idx, rd_q, LQ'(l)}];
         assign rd_b[l*DW +: DW] = mem[{rd_b_idx, rd_q, LQ'(l)}];
      end
   endgenerate

   assign t_rdata = mem[{t_idx, t_lane}];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int l = 0; l < LANES; l++)
            mem[{wr_idx, wr_q, LQ'(l)}] <= wr_data[l*DW +: DW];
      end else if (t_we) begin
         mem[{t_idx, t_lane}] <= t_wdata;
      end
   end
endmodule

// File: rtl/wsc_simd.sv
module wsc_simd
   import wsc_pkg::*;
#(
   parameter int DW      = 32,
   parameter int NREG    = 8,
   parameter int WAVE    = 64,
   parameter int LANES   = 16,
   parameter bit HAS_MUL = 1'b1,
   localparam int RIDX   = $clog2(NREG),
   localparam int LIDX   = $clog2(WAVE),
   localparam int QN     = WAVE / LANES,
   localparam int QIDX   = $clog2(QN)
)(
   input  logic            clk,
   input  logic            rst,
   input  logic            iss_valid,
   output logic            iss_ready,
   input  logic [OPW-1:0]  iss_op,
   input  logic [RIDX-1:0] iss_dst,
   input  logic [RIDX-1:0] iss_srca,
   input  logic [RIDX-1:0] iss_srcb,
   output logic            done,
   input  logic            t_we,
   input  logic [RIDX-1:0] t_idx,
   input  logic [LIDX-1:0] t_lane,
   input  logic [DW-1:0]   t_wdata,
   output logic [DW-1:0]   t_rdata
);
   localparam logic [QIDX-1:0] QLAST = QIDX'(QN - 1);

   logic            busy;
   logic [QIDX-1:0] qcnt;
   logic [OPW-1:0]  op_r;
   logic [RIDX-1:0] dst_r, sa_r, sb_r;

   logic            accept;
   logic [OPW-1:0]  cur_op;
   logic [RIDX-1:0] cur_dst, cur_sa, cur_sb;
   logic [QIDX-1:0] cur_q;
   logic            wr_en;
   logic            tw_ok;
   logic [LANES*DW-1:0] opa, opb, res;

   // Quarter 0 runs in the accepting cycle straight from the port fields.
   assign accept  = iss_valid && !busy;
   assign cur_op  = busy ? op_r  : iss_op;
   assign cur_dst = busy ? dst_r : iss_dst;
   assign cur_sa  = busy ? sa_r  : iss_srca;
   assign cur_sb  = busy ? sb_r  : iss_srcb;
   assign cur_q   = busy ? qcnt  : '0;
   assign wr_en   = (accept || busy) && op_writes(cur_op, HAS_MUL);
   assign tw_ok   = t_we && !busy && !iss_valid;

   assign iss_ready = !busy;
   assign done      = busy && (qcnt == QLAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         qcnt <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         qcnt <= QIDX'(1);
      end else if (busy) begin
         if (qcnt == QLAST) begin
            busy <= 1'b0;
            qcnt <= '0;
         end else begin
            qcnt <= qcnt + QIDX'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         op_r  <= iss_op;
         dst_r <= iss_dst;
         sa_r  <= iss_srca;
         sb_r  <= iss_srcb;
      end
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         wsc_lane_alu #(.DW(DW), .HAS_MUL(HAS_MUL)) u_alu (
            .op (cur_op),
            .a  (opa[l*DW +: DW]),
            .b  (opb[l*DW +: DW]),
            .y  (res[l*DW +: DW])
         );
      end
   endgenerate

   wsc_vrf #(.DW(DW), .NREG(NREG), .WAVE(WAVE), .LANES(LANES)) u_vrf (
      .clk      (clk),
      .rd_q     (cur_q),
      .rd_a_idx (cur_sa),
      .rd_b_idx (cur_sb),
      .rd_a     (opa),
      .rd_b     (opb),
      .wr_en    (wr_en),
      .wr_q     (cur_q),
      .wr_idx   (cur_dst),
      .wr_data  (res),
      .t_we     (tw_ok),
      .t_idx    (t_idx),
      .t_lane   (t_lane),
      .t_wdata  (t_wdata),
      .t_rdata  (t_rdata)
   );
endmodule

// File: rtl/wave_simd_core.sv
module wave_simd_core
   import wsc_pkg::*;
#(
   parameter int NS      = 4,
   parameter int LANES   = 16,
   parameter int WAVE    = 64,
   parameter int NREG    = 8,
   parameter int DW      = 32,
   parameter bit HAS_MUL = 1'b1,
   localparam int RIDX   = $clog2(NREG),
   localparam int LIDX   = $clog2(WAVE),
   localparam int SIDX   = $clog2(NS)
)(
   input  logic               clk,
   input  logic               rst,
   input  logic [NS-1:0]      iss_valid,
   output logic [NS-1:0]      iss_ready,
   input  logic [NS*OPW-1:0]  iss_op,
   input  logic [NS*RIDX-1:0] iss_dst,
   input  logic [NS*RIDX-1:0] iss_srca,
   input  logic [NS*RIDX-1:0] iss_srcb,
   output logic [NS-1:0]      done,
   input  logic [SIDX-1:0]    tst_simd,
   input  logic [RIDX-1:0]    tst_reg,
   input  logic [LIDX-1:0]    tst_lane,
   input  logic               tst_we,
   input  logic [DW-1:0]      tst_wdata,
   output logic [DW-1:0]      tst_rdata
);
   generate
      if (NS < 2 || (1 << SIDX) != NS) begin : g_bad_ns
         $error("NS must be a power of two of at least 2");
      end
      if (LANES < 1 || (1 << $clog2(LANES)) != LANES) begin : g_bad_lanes
         $error("LANES must be a power of two");
      end
      if (WAVE % LANES != 0 || WAVE / LANES < 2 || (1 << LIDX) != WAVE) begin : g_bad_wave
         $error("WAVE must be a power-of-two multiple of LANES, at least twice");
      end
      if (NREG < 2 || (1 << RIDX) != NREG) begin : g_bad_nreg
         $error("NREG must be a power of two of at least 2");
      end
   endgenerate

   logic [DW-1:0] rd_arr [NS];

   generate
      for (genvar s = 0; s < NS; s++) begin : g_simd
         logic sel;
         assign sel = (tst_simd == SIDX'(s));

         wsc_simd #(
            .DW(DW), .NREG(NREG), .WAVE(WAVE), .LANES(LANES), .HAS_MUL(HAS_MUL)
         ) u_simd (
            .clk       (clk),
            .rst       (rst),
            .iss_valid (iss_valid[s]),
            .iss_ready (iss_ready[s]),
            .iss_op    (iss_op[s*OPW +: OPW]),
            .iss_dst   (iss_dst[s*RIDX +: RIDX]),
            .iss_srca  (iss_srca[s*RIDX +: RIDX]),
            .iss_srcb  (iss_srcb[s*RIDX +: RIDX]),
            .done      (done[s]),
            .t_we      (tst_we && sel),
            .t_idx     (tst_reg),
            .t_lane    (tst_lane),
            .t_wdata   (tst_wdata),
            .t_rdata   (rd_arr[s])
         );
      end
   endgenerate

   assign tst_rdata = rd_arr[tst_simd];
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
   parameter int NS = 4
)(
   input logic          clk,
   input logic          rst,
   input logic [NS-1:0] iss_valid,
   input logic [NS-1:0] iss_ready,
   input logic [NS-1:0] done
);
   generate
      for (genvar s = 0; s < NS; s++) begin : g_chk
         // R5: acceptance closes the port for the following cycle
         assert_accept_blocks_R5: assert property (@(posedge clk) disable iff (rst)
            (iss_valid[s] && iss_ready[s]) |=> !iss_ready[s]);
         // R5: port stays closed until the completing cycle has passed
         assert_busy_holds_R5: assert property (@(posedge clk) disable iff (rst)
            (!iss_ready[s] && !done[s]) |=> !iss_ready[s]);
         // R6: completion pulse lasts one cycle
         assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
            done[s] |=> !done[s]);
         // R6: completion is followed by a free port
         assert_done_release_R6: assert property (@(posedge clk) disable iff (rst)
            done[s] |=> iss_ready[s]);
         // R6: completion only while executing
         assert_done_busy_R6: assert property (@(posedge clk) disable iff (rst)
            done[s] |-> !iss_ready[s]);
      end
   endgenerate
endmodule

bind wave_simd_core wsc_checker #(.NS(NS)) u_wsc_checker (
   .clk       (clk),
   .rst       (rst),
   .iss_valid (iss_valid),
   .iss_ready (iss_ready),
   .done      (done)
);

// File: tb/wave_simd_core_test.sv
`timescale 1ns/1ps
module wave_simd_core_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  iv = '0;
   wire  [3:0]  ir;
   wire  [3:0]  dn;
   logic [11:0] iop = '0, idst = '0, isa = '0, isb = '0;
   logic [1:0]  tsimd = '0;
   logic [2:0]  treg = '0;
   logic [5:0]  tlane = '0;
   logic        twe = 1'b0;
   logic [31:0] twdata = '0;
   wire  [31:0] trdata;

   int nchk = 0;
   int nfail = 0;
   logic [31:0] refm [4][8][64];

   always #2 clk = ~clk;

   wave_simd_core uut (
      .clk(clk), .rst(rst), .iss_valid(iv), .iss_ready(ir),
      .iss_op(iop), .iss_dst(idst), .iss_srca(isa), .iss_srcb(isb), .done(dn),
      .tst_simd(tsimd), .tst_reg(treg), .tst_lane(tlane), .tst_we(twe),
      .tst_wdata(twdata), .tst_rdata(trdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] alu(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return a ^ b;
         3'd5: return a * b;
         default: return 32'h0;
      endcase
   endfunction

   task automatic model(input int s, input logic [2:0] op, input int d, input int a, input int b);
      logic [31:0] t [64];
      for (int l = 0; l < 64; l++) t[l] = alu(op, refm[s][a][l], refm[s][b][l]);
      if (op <= 3'd5)
         for (int l = 0; l < 64; l++) refm[s][d][l] = t[l];
   endtask

   task automatic set_instr(input int s, input logic [2:0] op, input int d, input int a, input int b);
      iop[s*3 +: 3]  = op;
      idst[s*3 +: 3] = 3'(d);
      isa[s*3 +: 3]  = 3'(a);
      isb[s*3 +: 3]  = 3'(b);
   endtask

   task automatic tload(input int s, input int r, input int l, input logic [31:0] v);
      @(negedge clk);
      tsimd = 2'(s); treg = 3'(r); tlane = 6'(l); twdata = v; twe = 1'b1;
      @(posedge clk);
      #1 twe = 1'b0;
   endtask

   task automatic verify(input int s, input int r, input int lo, input int hi, input string req);
      int bad = -1;
      logic [31:0] got = '0;
      for (int l = lo; l <= hi; l++) begin
         tsimd = 2'(s); treg = 3'(r); tlane = 6'(l);
         #0.1;
         if (bad < 0 && trdata !== refm[s][r][l]) begin
            bad = l; got = trdata;
         end
      end
      if (bad < 0) check(1'b1, req, '0, '0);
      else check(1'b0, req, got, refm[s][r][bad]);
   endtask

   // Issue one instruction on engine s and check the full handshake timing.
   task automatic run_one(input int s, input logic [2:0] op, input int d, input int a, input int b, input string req);
      @(negedge clk);
      set_instr(s, op, d, a, b);
      iv[s] = 1'b1;
      #0.1 check(ir[s] === 1'b1, "R5 ready before issue", 32'(ir[s]), 1);
      @(posedge clk);
      #1 iv[s] = 1'b0;
      @(negedge clk);
      check(ir[s] === 1'b0 && dn[s] === 1'b0, "R5 cycle1", {ir[s], dn[s]}, 0);
      @(negedge clk);
      check(ir[s] === 1'b0 && dn[s] === 1'b0, "R5 cycle2", {ir[s], dn[s]}, 0);
      @(negedge clk);
      check(ir[s] === 1'b0 && dn[s] === 1'b1, "R6 done in cycle3", {ir[s], dn[s]}, 1);
      @(negedge clk);
      check(ir[s] === 1'b1 && dn[s] === 1'b0, "R6 free in cycle4", {ir[s], dn[s]}, 2);
      model(s, op, d, a, b);
      verify(s, d, 0, 63, req);
   endtask

   task automatic t_reset_state;
      check(ir === 4'hF, "R10 ready after reset", 32'(ir), 32'hF);
      check(dn === 4'h0, "R10 done low after reset", 32'(dn), 0);
   endtask

   task automatic t_load_all;
      for (int s = 0; s < 4; s++)
         for (int r = 0; r < 8; r++)
            for (int l = 0; l < 64; l++) begin
               refm[s][r][l] = 32'h9E3779B9 * 32'(s*512 + r*64 + l + 1) + 32'(l << 20);
               tload(s, r, l, refm[s][r][l]);
            end
      verify(1, 4, 0, 63, "R9 test port write/read");
   endtask

   task automatic t_arith;
      run_one(0, 3'd0, 2, 0, 1, "R1 add");
      run_one(0, 3'd1, 3, 2, 5, "R1 sub");
      run_one(1, 3'd2, 2, 0, 1, "R2 and");
      run_one(1, 3'd3, 3, 4, 5, "R2 or");
      run_one(1, 3'd4, 6, 6, 2, "R2 xor");
      run_one(2, 3'd5, 4, 0, 1, "R3 mul_lo");
      run_one(3, 3'd5, 5, 6, 7, "R3 mul_lo second pattern");
   endtask

   task automatic t_illegal;
      run_one(0, 3'd6, 4, 0, 1, "R4 opcode 6 no write");
      run_one(3, 3'd7, 0, 1, 2, "R4 opcode 7 no write");
   endtask

   task automatic t_alias;
      run_one(2, 3'd0, 3, 3, 3, "R7 dst equals both sources");
      run_one(2, 3'd1, 1, 0, 1, "R7 dst equals srcB");
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      set_instr(1, 3'd0, 7, 0, 1);
      iv[1] = 1'b1;
      @(posedge clk);
      #1 set_instr(1, 3'd4, 5, 7, 7 - 5);
      for (int c = 1; c <= 3; c++) begin
         @(negedge clk);
         check(ir[1] === 1'b0, "R5 back-to-back busy", 32'(ir[1]), 0);
      end
      check(dn[1] === 1'b1, "R6 first done", 32'(dn[1]), 1);
      @(negedge clk);
      check(ir[1] === 1'b1, "R5 reissue after four cycles", 32'(ir[1]), 1);
      @(posedge clk);
      #1 iv[1] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      check(dn[1] === 1'b1 && ir[1] === 1'b0, "R5 second done four cycles later", {ir[1], dn[1]}, 1);
      model(1, 3'd0, 7, 0, 1);
      model(1, 3'd4, 5, 7, 2);
      verify(1, 7, 0, 63, "R5 first result");
      verify(1, 5, 0, 63, "R5 dependent result");
   endtask

   task automatic t_concurrent;
      @(negedge clk);
      set_instr(0, 3'd0, 6, 1, 2);
      set_instr(1, 3'd1, 6, 1, 2);
      set_instr(2, 3'd4, 6, 1, 2);
      set_instr(3, 3'd5, 6, 1, 2);
      iv = 4'hF;
      @(posedge clk);
      #1 iv = 4'h0;
      @(negedge clk);
      check(ir === 4'h0, "R8 all busy", 32'(ir), 0);
      @(negedge clk);
      @(negedge clk);
      check(dn === 4'hF, "R8 all done together", 32'(dn), 32'hF);
      @(negedge clk);
      check(ir === 4'hF, "R8 all free", 32'(ir), 32'hF);
      model(0, 3'd0, 6, 1, 2);
      model(1, 3'd1, 6, 1, 2);
      model(2, 3'd4, 6, 1, 2);
      model(3, 3'd5, 6, 1, 2);
      for (int s = 0; s < 4; s++) verify(s, 6, 0, 63, "R8 per-engine result");
      for (int s = 0; s < 4; s++) verify(s, 7, 0, 63, "R8 other register untouched");
   endtask

   task automatic t_test_lockout;
      @(negedge clk);
      set_instr(3, 3'd0, 4, 0, 1);
      iv[3] = 1'b1;
      tsimd = 2'd3; treg = 3'd7; tlane = 6'd9; twdata = 32'hDEAD_BEEF; twe = 1'b1;
      @(posedge clk);
      #1 iv[3] = 1'b0;
      @(negedge clk);
      tsimd = 2'd3; treg = 3'd7; tlane = 6'd40; twdata = 32'hCAFE_0001; twe = 1'b1;
      @(posedge clk);
      #1 tsimd = 2'd0; treg = 3'd7; tlane = 6'd3; twdata = 32'h1234_5678;
      @(posedge clk);
      #1 twe = 1'b0;
      refm[0][7][3] = 32'h1234_5678;
      @(negedge clk);
      @(negedge clk);
      model(3, 3'd0, 4, 0, 1);
      verify(3, 7, 0, 63, "R9 write ignored while engine busy or issuing");
      verify(0, 7, 0, 63, "R9 write to idle engine lands");
      verify(3, 4, 0, 63, "R9 instruction unaffected");
   endtask

   task automatic t_mid_reset;
      @(negedge clk);
      set_instr(2, 3'd0, 5, 0, 1);
      iv[2] = 1'b1;
      @(posedge clk);
      #1 iv[2] = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check(ir === 4'hF && dn === 4'h0, "R10 mid-instruction reset", {ir, dn}, 32'hF0);
      verify(2, 5, 32, 63, "R10 unreached quarters keep contents");
      verify(2, 0, 0, 63, "R10 source kept");
      @(negedge clk);
      check(dn === 4'h0, "R10 no late done", 32'(dn), 0);
      for (int l = 0; l < 32; l++) tload(2, 5, l, refm[2][5][l]);
      run_one(2, 3'd2, 5, 5, 0, "R10 engine usable after reset");
   endtask

   initial begin
      #(4.0 * 150000);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      t_reset_state();
      t_load_all();
      t_arith();
      t_illegal();
      t_alias();
      t_back_to_back();
      t_concurrent();
      t_test_lockout();
      t_mid_reset();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule